// File: doc/BRIEF.md
# Privilege-Checked Segment Address Decoder

This block sits in front of the memory management unit of a 32-bit processor core. For each access it takes the virtual address, the access direction, the current privilege mode and the error-level flag, and sorts the address into one of five fixed regions. Two kernel regions are translated directly by subtracting a fixed base. The user region and the two upper kernel/supervisor regions are sent to an external translation lookaside buffer, whose result comes back on the same cycle. One exception is the user region while the error-level flag is set: it is passed through untranslated.

Everything on the lookup path is combinational. It produces a physical address, a fault flag, a five-bit exception code and a refill marker in the same cycle as the address. When the core commits a faulting access by pulsing a strobe, three fault registers are loaded on the next clock edge: the faulting address, a context word holding the packed virtual page number, and an entry-high word that keeps its address-space identifier.

Top module: `seg_xlate_unit`

## Requirements
- R1: With the error-level flag clear, an address below 0x80000000 is accepted in every mode. The unit raises tlbLookup and drives paddr with tlbPaddr when tlbResult is 00 (hit).
- R2: With the error-level flag set, an address below 0x80000000 gives paddr equal to vaddr, no lookup and no fault, whatever tlbResult holds.
- R3: An address in 0x80000000..0x9FFFFFFF in kernel mode (privMode 00) gives paddr = vaddr - 0x80000000 with no lookup.
- R4: An address in 0xA0000000..0xBFFFFFFF in kernel mode gives paddr = vaddr - 0xA0000000 with no lookup.
- R5: An address in 0xC0000000..0xDFFFFFFF is looked up in kernel or supervisor mode (01). In user mode it is an address error.
- R6: An address at 0xE0000000 or above is looked up in kernel mode only. In any other mode it is an address error.
- R7: An address error sets faultValid with excCode 4 on a read and 5 on a write (isWrite=1). Whenever faultValid is high, paddr is 0.
- R8: A tlbResult of 01 (no match) on a looked-up access gives excCode 2 on a read and 3 on a write, with refillFault=1. A tlbResult of 10 (invalid) gives the same codes with refillFault=0.
- R9: A tlbResult of 11 (modify) on a looked-up access gives excCode 1 with refillFault=0.
- R10: On a clock edge where commitFault and faultValid are both high, badVaddr takes vaddr. contextReg bits 22:4 take vaddr bits 31:13 and its other bits are kept. entryHi takes vaddr with bits 12:0 cleared, keeping its low 8 identifier bits.
- R11: On an edge where commitFault is low, or faultValid is low, the three fault registers keep their values.
- R12: privMode 11 behaves as user mode.
- R13: After reset, badVaddr is 0, contextReg is CTX_RESET (default 0xFF80000F), and entryHi holds only ASID_RESET (default 0x5A) in its low 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| vaddr | input | 32 | Virtual address of the access |
| isWrite | input | 1 | 1 for a store, 0 for a load |
| privMode | input | 2 | 00 kernel, 01 supervisor, 10/11 user |
| errLevel | input | 1 | Error-level flag; bypasses lookup of the user region |
| tlbResult | input | 2 | Lookup outcome: 00 hit, 01 no match, 10 invalid, 11 modify |
| tlbPaddr | input | 32 | Physical address from the lookup |
| commitFault | input | 1 | Strobe: load fault registers if faulting |
| tlbLookup | output | 1 | Access is forwarded to the lookup |
| paddr | output | 32 | Physical address (0 on fault) |
| faultValid | output | 1 | Access faults |
| excCode | output | 5 | Exception code (0 if no fault) |
| refillFault | output | 1 | Fault is a lookup miss needing refill |
| badVaddr | output | 32 | Captured faulting address |
| contextReg | output | 32 | Context word with packed page number |
| entryHi | output | 32 | Page pair number and identifier |

## Verification
The hardest case to reach from the ports is the distinction between a fault that is flagged and one that is actually committed. The registers must ignore commit strobes that arrive without a fault, and they must also ignore faults that arrive without a strobe. The stimulus first commits a real fault, then holds the strobe high on a clean kernel access, and then presents a no-match fault with the strobe low. After each of these steps it reads all three registers. Since the identifier bits can only be set by reset, a nonzero reset default is used to show that they survive a capture.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [1:0] {
    TLB_HIT     = 2'b00,
    TLB_NOMATCH = 2'b01,
    TLB_INVALID = 2'b10,
    TLB_MODIFY  = 2'b11
  } tlbRes_e;

  typedef enum logic [2:0] {
    SEG_USER,
    SEG_KDIRECT0,
    SEG_KDIRECT1,
    SEG_SUPMAP,
    SEG_KMAP
  } seg_e;

  localparam logic [1:0] MODE_KERNEL = 2'b00;
  localparam logic [1:0] MODE_SUPER  = 2'b01;

  localparam logic [4:0] EXC_NONE     = 5'd0;
  localparam logic [4:0] EXC_MODIFY   = 5'd1;
  localparam logic [4:0] EXC_TLB_LD   = 5'd2;
  localparam logic [4:0] EXC_TLB_ST   = 5'd3;
  localparam logic [4:0] EXC_ADDR_LD  = 5'd4;
  localparam logic [4:0] EXC_ADDR_ST  = 5'd5;

  // strobes from control to datapath
  typedef struct packed {
    logic selTlb;
    logic selMinus0;
    logic selMinus1;
    logic blockOut;
    logic capture;
  } dpCtrl_t;

endpackage

// File: rtl/seg_xlate_ctrl.sv
module seg_xlate_ctrl
  import seg_xlate_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [2:0]           segBits,
  input  logic                 isWrite,
  input  logic [1:0]           privMode,
  input  logic                 errLevel,
  input  logic [1:0]           tlbResult,
  input  logic                 commitFault,
  output dpCtrl_t              dpCtrl,
  output logic                 tlbLookup,
  output logic                 faultValid,
  output logic [4:0]           excCode,
  output logic                 refillFault
);

  seg_e    seg;
  tlbRes_e tlbRes;
  logic    isKernel, isSuper;
  logic    allowed, mapped, addrErr, tlbErr;

  assign tlbRes   = tlbRes_e'(tlbResult);
  assign isKernel = (privMode == MODE_KERNEL);
  assign isSuper  = (privMode == MODE_SUPER);

  always_comb begin
    unique casez (segBits)
      3'b0??:  seg = SEG_USER;
      3'b100:  seg = SEG_KDIRECT0;
      3'b101:  seg = SEG_KDIRECT1;
      3'b110:  seg = SEG_SUPMAP;
      default: seg = SEG_KMAP;
    endcase
  end

  always_comb begin
    allowed = 1'b0;
    mapped  = 1'b0;
    unique case (seg)
      SEG_USER:     begin allowed = 1'b1;               mapped = !errLevel; end
      SEG_KDIRECT0: begin allowed = isKernel;           mapped = 1'b0;      end
      SEG_KDIRECT1: begin allowed = isKernel;           mapped = 1'b0;      end
      SEG_SUPMAP:   begin allowed = isKernel | isSuper; mapped = 1'b1;      end
      default:      begin allowed = isKernel;           mapped = 1'b1;      end
    endcase
  end

  assign addrErr    = !allowed;
  assign tlbLookup  = allowed && mapped;
  assign tlbErr     = tlbLookup && (tlbRes != TLB_HIT);
  assign faultValid = addrErr || tlbErr;

  always_comb begin
    excCode     = EXC_NONE;
    refillFault = 1'b0;
    if (addrErr) begin
      excCode = isWrite ? EXC_ADDR_ST : EXC_ADDR_LD;
    end else if (tlbErr) begin
      unique case (tlbRes)
        TLB_NOMATCH: begin
          excCode     = isWrite ? EXC_TLB_ST : EXC_TLB_LD;
          refillFault = 1'b1;
        end
        TLB_INVALID: excCode = isWrite ? EXC_TLB_ST : EXC_TLB_LD;
        default:     excCode = EXC_MODIFY;
      endcase
    end
  end

  always_comb begin
    dpCtrl.selTlb    = tlbLookup;
    dpCtrl.selMinus0 = allowed && (seg == SEG_KDIRECT0);
    dpCtrl.selMinus1 = allowed && (seg == SEG_KDIRECT1);
    dpCtrl.blockOut  = faultValid;
    dpCtrl.capture   = faultValid && commitFault;
  end

  // R2: unmapped user region under error level never faults
  p_errlevel_nofault_r2: assert property (@(posedge clk) disable iff (!rstN)
    (errLevel && !segBits[2]) |-> (!faultValid && !tlbLookup));

  // R8: refill marker only with a lookup-miss code
  p_refill_code_r8: assert property (@(posedge clk) disable iff (!rstN)
    refillFault |-> (faultValid && (excCode == EXC_TLB_LD || excCode == EXC_TLB_ST)));

  // R3: direct kernel region outside kernel mode is an address error
  p_kdirect_priv_r3: assert property (@(posedge clk) disable iff (!rstN)
    (segBits[2:1] == 2'b10 && privMode != MODE_KERNEL) |->
      (faultValid && (excCode == EXC_ADDR_LD || excCode == EXC_ADDR_ST)));

  // R7: exception code is nonzero exactly when faulting
  p_code_fault_r7: assert property (@(posedge clk) disable iff (!rstN)
    faultValid == (excCode != EXC_NONE));

endmodule

// File: rtl/seg_xlate_dp.sv
module seg_xlate_dp
  import seg_xlate_pkg::*;
#(
  parameter int ADDR_W              = 32,
  parameter int ASID_W              = 8,
  parameter int PAGE_BITS           = 12,
  parameter int CTX_LSB             = 4,
  parameter logic [31:0] CTX_RESET  = 32'hFF80_000F,
  parameter logic [7:0]  ASID_RESET = 8'h5A
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           dpCtrl,
  input  logic [ADDR_W-1:0] vaddr,
  input  logic [ADDR_W-1:0] tlbPaddr,
  output logic [ADDR_W-1:0] paddr,
  output logic [ADDR_W-1:0] badVaddr,
  output logic [ADDR_W-1:0] contextReg,
  output logic [ADDR_W-1:0] entryHi
);

  localparam int VPN2_LSB    = PAGE_BITS + 1;
  localparam int VPN2_W      = ADDR_W - VPN2_LSB;
  localparam int EHI_GAP     = VPN2_LSB - ASID_W;
  localparam logic [ADDR_W-1:0] BASE0 = ADDR_W'(32'h8000_0000);
  localparam logic [ADDR_W-1:0] BASE1 = ADDR_W'(32'hA000_0000);

  logic [ADDR_W-1:0] ctxNext, ehiNext;

  always_comb begin
    if (dpCtrl.blockOut)       paddr = '0;
    else if (dpCtrl.selTlb)    paddr = tlbPaddr;
    else if (dpCtrl.selMinus0) paddr = vaddr - BASE0;
    else if (dpCtrl.selMinus1) paddr = vaddr - BASE1;
    else                       paddr = vaddr;
  end

  always_comb begin
    ctxNext = contextReg;
    ctxNext[CTX_LSB +: VPN2_W] = vaddr[ADDR_W-1:VPN2_LSB];
    ehiNext = {vaddr[ADDR_W-1:VPN2_LSB], {EHI_GAP{1'b0}}, entryHi[ASID_W-1:0]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      badVaddr   <= '0;
      contextReg <= ADDR_W'(CTX_RESET);
      entryHi    <= ADDR_W'(ASID_RESET);
    end else if (dpCtrl.capture) begin
      badVaddr   <= vaddr;
      contextReg <= ctxNext;
      entryHi    <= ehiNext;
    end
  end

  // R10: committed fault loads the faulting address
  p_capture_addr_r10: assert property (@(posedge clk) disable iff (!rstN)
    dpCtrl.capture |=> (badVaddr == $past(vaddr)));

  // R10: identifier and context side bits survive a capture
  p_keep_fields_r10: assert property (@(posedge clk) disable iff (!rstN)
    dpCtrl.capture |=> (entryHi[ASID_W-1:0] == $past(entryHi[ASID_W-1:0]) &&
                        contextReg[CTX_LSB-1:0] == $past(contextReg[CTX_LSB-1:0])));

  // R11: no capture, no change
  p_hold_regs_r11: assert property (@(posedge clk) disable iff (!rstN)
    !dpCtrl.capture |=> ($stable(badVaddr) && $stable(contextReg) && $stable(entryHi)));

  // R7: faulting access drives a zero address
  p_zero_on_fault_r7: assert property (@(posedge clk) disable iff (!rstN)
    dpCtrl.blockOut |-> (paddr == '0));

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import seg_xlate_pkg::*;
#(
  parameter int ADDR_W              = 32,
  parameter int ASID_W              = 8,
  parameter int PAGE_BITS           = 12,
  parameter int CTX_LSB             = 4,
  parameter logic [31:0] CTX_RESET  = 32'hFF80_000F,
  parameter logic [7:0]  ASID_RESET = 8'h5A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] vaddr,
  input  logic              isWrite,
  input  logic [1:0]        privMode,
  input  logic              errLevel,
  input  logic [1:0]        tlbResult,
  input  logic [ADDR_W-1:0] tlbPaddr,
  input  logic              commitFault,
  output logic              tlbLookup,
  output logic [ADDR_W-1:0] paddr,
  output logic              faultValid,
  output logic [4:0]        excCode,
  output logic              refillFault,
  output logic [ADDR_W-1:0] badVaddr,
  output logic [ADDR_W-1:0] contextReg,
  output logic [ADDR_W-1:0] entryHi
);

  dpCtrl_t dpCtrl;

  seg_xlate_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .segBits     (vaddr[ADDR_W-1:ADDR_W-3]),
    .isWrite     (isWrite),
    .privMode    (privMode),
    .errLevel    (errLevel),
    .tlbResult   (tlbResult),
    .commitFault (commitFault),
    .dpCtrl      (dpCtrl),
    .tlbLookup   (tlbLookup),
    .faultValid  (faultValid),
    .excCode     (excCode),
    .refillFault (refillFault)
  );

  seg_xlate_dp #(
    .ADDR_W     (ADDR_W),
    .ASID_W     (ASID_W),
    .PAGE_BITS  (PAGE_BITS),
    .CTX_LSB    (CTX_LSB),
    .CTX_RESET  (CTX_RESET),
    .ASID_RESET (ASID_RESET)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .dpCtrl     (dpCtrl),
    .vaddr      (vaddr),
    .tlbPaddr   (tlbPaddr),
    .paddr      (paddr),
    .badVaddr   (badVaddr),
    .contextReg (contextReg),
    .entryHi    (entryHi)
  );

endmodule

// File: tb/sim_seg_xlate_unit.sv
module sim_seg_xlate_unit;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] CTX_RST = 32'hFF80_000F;
  localparam logic [31:0] ASID_RST = 32'h0000_005A;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] vaddr = '0;
  logic        isWrite = 1'b0;
  logic [1:0]  privMode = 2'b00;
  logic        errLevel = 1'b0;
  logic [1:0]  tlbResult = 2'b00;
  logic [31:0] tlbPaddr = '0;
  logic        commitFault = 1'b0;
  logic        tlbLookup, faultValid, refillFault;
  logic [31:0] paddr, badVaddr, contextReg, entryHi;
  logic [4:0]  excCode;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  seg_xlate_unit u0 (
    .clk(clk), .rstN(rstN), .vaddr(vaddr), .isWrite(isWrite),
    .privMode(privMode), .errLevel(errLevel), .tlbResult(tlbResult),
    .tlbPaddr(tlbPaddr), .commitFault(commitFault), .tlbLookup(tlbLookup),
    .paddr(paddr), .faultValid(faultValid), .excCode(excCode),
    .refillFault(refillFault), .badVaddr(badVaddr), .contextReg(contextReg),
    .entryHi(entryHi)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic apply(logic [31:0] va, logic wr, logic [1:0] md, logic el,
                       logic [1:0] tr, logic [31:0] tp);
    @(negedge clk);
    vaddr = va; isWrite = wr; privMode = md; errLevel = el;
    tlbResult = tr; tlbPaddr = tp;
    #1;
  endtask

  task automatic test_reset();
    check("R13 badVaddr", badVaddr, 32'h0);
    check("R13 context", contextReg, CTX_RST);
    check("R13 entryHi", entryHi, ASID_RST);
  endtask

  task automatic test_user_region();
    for (int m = 0; m < 4; m++) begin
      apply(32'h1234_5678, 1'b0, 2'(m), 1'b0, 2'b00, 32'h0ABC_D678);
      check(m == 3 ? "R12 user lookup" : "R1 user lookup", {31'b0, tlbLookup}, 32'h1);
      check("R1 user paddr", paddr, 32'h0ABC_D678);
      check("R1 user nofault", {31'b0, faultValid}, 32'h0);
    end
  endtask

  task automatic test_errlevel();
    apply(32'h7FFF_F000, 1'b1, 2'b10, 1'b1, 2'b01, 32'h1111_1111);
    check("R2 paddr", paddr, 32'h7FFF_F000);
    check("R2 nofault", {31'b0, faultValid}, 32'h0);
    check("R2 nolookup", {31'b0, tlbLookup}, 32'h0);
  endtask

  task automatic test_direct();
    apply(32'h8123_4560, 1'b0, 2'b00, 1'b0, 2'b01, 32'h0);
    check("R3 paddr", paddr, 32'h0123_4560);
    check("R3 nolookup", {31'b0, tlbLookup}, 32'h0);
    apply(32'h9FFF_FFFF, 1'b0, 2'b10, 1'b0, 2'b00, 32'h0);
    check("R7 load code", {27'b0, excCode}, 32'd4);
    check("R7 zero paddr", paddr, 32'h0);
    apply(32'h8000_0000, 1'b1, 2'b01, 1'b0, 2'b00, 32'h0);
    check("R7 store code", {27'b0, excCode}, 32'd5);
    apply(32'hBFC0_0000, 1'b0, 2'b00, 1'b0, 2'b00, 32'h0);
    check("R4 paddr", paddr, 32'h1FC0_0000);
    check("R4 nofault", {31'b0, faultValid}, 32'h0);
    apply(32'hA000_0000, 1'b0, 2'b11, 1'b0, 2'b00, 32'h0);
    check("R12 mode11 fault", {27'b0, excCode}, 32'd4);
  endtask

  task automatic test_mapped_kernel();
    apply(32'hC000_1000, 1'b0, 2'b01, 1'b0, 2'b00, 32'h0200_1000);
    check("R5 sup paddr", paddr, 32'h0200_1000);
    check("R5 sup lookup", {31'b0, tlbLookup}, 32'h1);
    apply(32'hDFFF_0000, 1'b0, 2'b10, 1'b0, 2'b00, 32'h0200_1000);
    check("R5 user code", {27'b0, excCode}, 32'd4);
    check("R5 user nolookup", {31'b0, tlbLookup}, 32'h0);
    apply(32'hE000_0000, 1'b0, 2'b00, 1'b0, 2'b00, 32'h0300_0000);
    check("R6 kernel paddr", paddr, 32'h0300_0000);
    apply(32'hFFFF_FFFC, 1'b1, 2'b01, 1'b0, 2'b00, 32'h0300_0000);
    check("R6 sup code", {27'b0, excCode}, 32'd5);
  endtask

  task automatic test_tlb_faults();
    apply(32'h0040_0000, 1'b0, 2'b10, 1'b0, 2'b01, 32'h0);
    check("R8 nomatch ld", {27'b0, excCode}, 32'd2);
    check("R8 refill", {31'b0, refillFault}, 32'h1);
    apply(32'h0040_0000, 1'b1, 2'b10, 1'b0, 2'b01, 32'h0);
    check("R8 nomatch st", {27'b0, excCode}, 32'd3);
    apply(32'hC040_0000, 1'b0, 2'b00, 1'b0, 2'b10, 32'h0);
    check("R8 invalid ld", {27'b0, excCode}, 32'd2);
    check("R8 invalid norefill", {31'b0, refillFault}, 32'h0);
    apply(32'hE040_0000, 1'b1, 2'b00, 1'b0, 2'b10, 32'h0);
    check("R8 invalid st", {27'b0, excCode}, 32'd3);
    apply(32'h0050_0000, 1'b1, 2'b00, 1'b0, 2'b11, 32'h0);
    check("R9 modify code", {27'b0, excCode}, 32'd1);
    check("R9 norefill", {31'b0, refillFault}, 32'h0);
  endtask

  task automatic test_capture();
    logic [31:0] va, expCtx, expEhi;
    va = 32'hC3A5_7F21;
    expCtx = (CTX_RST & ~32'h007F_FFF0) | ((va >> 9) & 32'h007F_FFF0);
    expEhi = (va & 32'hFFFF_E000) | ASID_RST;
    apply(va, 1'b1, 2'b10, 1'b0, 2'b00, 32'h0);
    commitFault = 1'b1;
    @(negedge clk);
    commitFault = 1'b0;
    #1;
    check("R10 badVaddr", badVaddr, va);
    check("R10 context", contextReg, expCtx);
    check("R10 entryHi", entryHi, expEhi);
    apply(32'h8000_4000, 1'b0, 2'b00, 1'b0, 2'b00, 32'h0);
    commitFault = 1'b1;
    @(negedge clk);
    commitFault = 1'b0;
    #1;
    check("R11 commit no fault", badVaddr, va);
    check("R11 ctx kept", contextReg, expCtx);
    apply(32'h0777_0000, 1'b0, 2'b10, 1'b0, 2'b01, 32'h0);
    @(negedge clk);
    #1;
    check("R11 fault no commit", badVaddr, va);
    check("R11 ehi kept", entryHi, expEhi);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    test_reset();
    test_user_region();
    test_errlevel();
    test_direct();
    test_mapped_kernel();
    test_tlb_faults();
    test_capture();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule